// File: doc/BRIEF.md
# Single-Context External Interrupt Controller

This block collects a handful of level-sensitive interrupt requests and turns them into one machine-level external interrupt line for a single processor hart. Source 1 is the receive-data-valid signal of a UART. The remaining sources arrive on a small auxiliary vector. Each source carries a programmable priority, an enable bit and a pending bit. A single context threshold decides which sources are allowed to interrupt.

Software reaches the controller through a 32-bit register port. It reads the claim/complete register to find out which source to service. That read also moves the source into service. Software then writes the same ID back to release the source. Each source runs a three-state gateway: `GW_IDLE` goes to `GW_PENDING` when its level is high, `GW_PENDING` goes to `GW_INFLIGHT` when it is claimed, and `GW_INFLIGHT` goes back to `GW_IDLE` when its ID is completed. The bus port is a two-state machine: `BUS_IDLE` goes to `BUS_ACK` when it accepts a request, and `BUS_ACK` always returns to `BUS_IDLE`.

Top module: `ext_irq_hub`

## Requirements
- R1: After reset, every register reads zero: each source priority, the pending word, the enable word, the threshold and claim/complete. `irq_out` is low.
- R2: The priority of source k is read/write at byte offset 4*k and keeps only the low 3 bits, so writing 0xF reads back 7. Offset 0 (source 0) always reads zero.
- R3: The enable word at offset 0x002000 is read/write. Bit k enables source k. Bit 0 and the bits above the last source always read zero, so writing 0xFFFFFFFF with three sources reads back 0xE.
- R4: The threshold at offset 0x200000 is read/write, 3 bits wide.
- R5: A source whose level is high while its gateway is idle sets bit k of the read-only pending word at offset 0x001000 on the next clock edge.
- R6: `irq_out` is registered. It is high exactly one clock after some source is pending, enabled, and has a priority strictly greater than the threshold.
- R7: Reading claim/complete at offset 0x200004 returns the ID of the eligible pending source with the highest priority and clears that source's pending bit. It returns 0 when no source is eligible.
- R8: When several eligible sources share the highest priority, the claim returns the lowest ID.
- R9: Between its claim and the write of its own ID to claim/complete, a source does not become pending again and cannot be claimed. Writing any other ID does not release it. If its level is still high after the completing write, it becomes pending again.
- R10: Writes to the pending word are ignored, and reads of unmapped offsets return zero.
- R11: A request accepted while the port is idle is answered by `bus_ack`, a single-cycle pulse in the following cycle, with read data valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from the controller base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access completion pulse |
| uart_rx_valid | input | 1 | UART receive-data-valid level, source 1 |
| aux_irq | input | NUM_SRC-1 | Levels of sources 2 to NUM_SRC |
| irq_out | output | 1 | External interrupt request to the hart |

## Verification
The bench sweeps every priority/threshold pair for source 1 and every priority triple across three sources. A controller that compared with greater-or-equal, or that broke ties toward the highest ID, would return the wrong claim ID or raise the line when it should stay low. It then holds a source level high across a claim. A gateway without an in-service state would show the pending bit again, or hand out the same ID twice. A wrong-ID complete would release it early. It also times `irq_out` against the pending edge, so a combinational or doubly-registered line shows up a cycle off. Finally it writes to the read-only pending word and to unmapped offsets, to catch decode that is too loose.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        GW_IDLE     = 2'd0,
        GW_PENDING  = 2'd1,
        GW_INFLIGHT = 2'd2
    } gw_state_t;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_t;

    localparam logic [31:0] OFS_PEND   = 32'h0000_1000;
    localparam logic [31:0] OFS_ENABLE = 32'h0000_2000;
    localparam logic [31:0] OFS_THRESH = 32'h0020_0000;
    localparam logic [31:0] OFS_CLAIM  = 32'h0020_0004;

endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic claim,
    input  logic done,
    output logic pending,
    output logic in_flight
);

    gw_state_t state_q;
    gw_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: begin
                if (level) begin
                    state_d = GW_PENDING;
                end
            end
            GW_PENDING: begin
                if (claim) begin
                    state_d = GW_INFLIGHT;
                end
            end
            GW_INFLIGHT: begin
                if (done) begin
                    state_d = GW_IDLE;
                end
            end
            default: state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending   = (state_q == GW_PENDING);
        in_flight = (state_q == GW_INFLIGHT);
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 3,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]          pend,
    input  logic [NUM_SRC:1]          enable,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      best_valid,
    output logic [ID_W-1:0]           best_id
);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        best_prio = thresh;
        best_id   = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (pend[i] && enable[i] &&
                (prio_flat[(i-1)*PRIO_W +: PRIO_W] > best_prio)) begin
                best_prio = prio_flat[(i-1)*PRIO_W +: PRIO_W];
                best_id   = ID_W'(i);
            end
        end
        best_valid = (best_id != '0);
    end

endmodule

// File: rtl/irqc_bus_fsm.sv
module irqc_bus_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic accept,
    output logic ack
);

    bus_state_t state_q;
    bus_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (req) begin
                    state_d = BUS_ACK;
                end
            end
            BUS_ACK: state_d = BUS_IDLE;
            default: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        accept = (state_q == BUS_IDLE) && req;
        ack    = (state_q == BUS_ACK);
    end

endmodule

// File: rtl/ext_irq_hub.sv
module ext_irq_hub
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_ack,
    input  logic               uart_rx_valid,
    input  logic [NUM_SRC-2:0] aux_irq,
    output logic               irq_out
);

    localparam int ID_W = $clog2(NUM_SRC + 1);

    logic [31:0]              addr32;
    logic                     accept;
    logic                     wr_acc;
    logic                     rd_acc;
    logic [NUM_SRC:1]         src_lvl;
    logic [NUM_SRC:1]         pend;
    logic [NUM_SRC:1]         active;
    logic [NUM_SRC:1]         claim_stb;
    logic [NUM_SRC:1]         done_stb;
    logic [NUM_SRC:1]         enable_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [PRIO_W-1:0]        thresh_q;
    logic                     best_valid;
    logic [ID_W-1:0]          best_id;
    logic [31:0]              rd_mux;
    logic [31:0]              rdata_q;
    logic                     irq_q;
    logic                     claim_rd;
    logic                     claim_wr;

    assign addr32   = 32'(bus_addr);
    assign src_lvl  = {aux_irq, uart_rx_valid};
    assign wr_acc   = accept && bus_we;
    assign rd_acc   = accept && !bus_we;
    assign claim_rd = rd_acc && (addr32 == OFS_CLAIM);
    assign claim_wr = wr_acc && (addr32 == OFS_CLAIM);

    irqc_bus_fsm u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .accept (accept),
        .ack    (bus_ack)
    );

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
        logic [PRIO_W-1:0] prio_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q <= '0;
            end else if (wr_acc && (addr32 == 32'(4 * g))) begin
                prio_q <= bus_wdata[PRIO_W-1:0];
            end
        end

        assign prio_flat[(g-1)*PRIO_W +: PRIO_W] = prio_q;
        assign claim_stb[g] = claim_rd && best_valid && (best_id == ID_W'(g));
        assign done_stb[g]  = claim_wr && (bus_wdata == 32'(g));

        irqc_gateway u_gw (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (src_lvl[g]),
            .claim     (claim_stb[g]),
            .done      (done_stb[g]),
            .pending   (pend[g]),
            .in_flight (active[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            thresh_q <= '0;
        end else if (wr_acc) begin
            if (addr32 == OFS_ENABLE) begin
                enable_q <= bus_wdata[NUM_SRC:1];
            end
            if (addr32 == OFS_THRESH) begin
                thresh_q <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    irqc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .pend       (pend),
        .enable     (enable_q),
        .prio_flat  (prio_flat),
        .thresh     (thresh_q),
        .best_valid (best_valid),
        .best_id    (best_id)
    );

    always_comb begin
        rd_mux = '0;
        if (addr32 == OFS_PEND) begin
            rd_mux[NUM_SRC:0] = {pend, 1'b0};
        end else if (addr32 == OFS_ENABLE) begin
            rd_mux[NUM_SRC:0] = {enable_q, 1'b0};
        end else if (addr32 == OFS_THRESH) begin
            rd_mux[PRIO_W-1:0] = thresh_q;
        end else if (addr32 == OFS_CLAIM) begin
            rd_mux[ID_W-1:0] = best_id;
        end else begin
            for (int i = 1; i <= NUM_SRC; i++) begin
                if (addr32 == 32'(4 * i)) begin
                    rd_mux[PRIO_W-1:0] = prio_flat[(i-1)*PRIO_W +: PRIO_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= best_valid;
            if (rd_acc) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = irq_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_SRC = 3,
    parameter int PRIO_W  = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_req,
    input logic                      bus_ack,
    input logic                      irq_out,
    input logic [NUM_SRC:1]          pend,
    input logic [NUM_SRC:1]          active,
    input logic [NUM_SRC:1]          src_lvl,
    input logic [NUM_SRC:1]          enable_q,
    input logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input logic [PRIO_W-1:0]         thresh_q
);

    logic elig_any;

    always_comb begin
        elig_any = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (pend[i] && enable_q[i] &&
                (prio_flat[(i-1)*PRIO_W +: PRIO_W] > thresh_q)) begin
                elig_any = 1'b1;
            end
        end
    end

    a_r11_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r11_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(bus_req));

    a_r6_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(elig_any));

    a_r9_no_repend_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & $past(active)) == '0);

    a_r5_pend_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(src_lvl)) == '0);

endmodule

bind ext_irq_hub irqc_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .irq_out   (irq_out),
    .pend      (pend),
    .active    (active),
    .src_lvl   (src_lvl),
    .enable_q  (enable_q),
    .prio_flat (prio_flat),
    .thresh_q  (thresh_q)
);

// File: tb/ext_irq_hub_tb.sv
module ext_irq_hub_tb;

    localparam int NUM_SRC = 3;
    localparam int ADDR_W  = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ack;
    logic              uart_rx_valid = 1'b0;
    logic [1:0]        aux_irq = '0;
    logic              irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_irq_hub #(.NUM_SRC(NUM_SRC), .PRIO_W(3), .ADDR_W(ADDR_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_ack       (bus_ack),
        .uart_rx_valid (uart_rx_valid),
        .aux_irq       (aux_irq),
        .irq_out       (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = addr[ADDR_W-1:0];
        bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R11 ack", 32'(bus_ack), 32'd1);
        rd = bus_rdata;
        @(negedge clk);
        chk("R11 ack pulse", 32'(bus_ack), 32'd0);
    endtask

    task automatic wr(input logic [31:0] addr, input logic [31:0] wd);
        logic [31:0] dummy;
        bus_op(1'b1, addr, wd, dummy);
    endtask

    task automatic rd(input logic [31:0] addr, output logic [31:0] d);
        bus_op(1'b0, addr, 32'd0, d);
    endtask

    task automatic pulse(input logic [3:1] lv);
        @(negedge clk);
        uart_rx_valid = lv[1];
        aux_irq       = lv[3:2];
        @(negedge clk);
        uart_rx_valid = 1'b0;
        aux_irq       = '0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [3:1]  pm;
        int          pr [1:3];
        int          exp_id;
        int          best;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_out", 32'(irq_out), 0);
        for (int k = 0; k <= 3; k++) begin
            rd(32'(4 * k), d);
            chk("R1 prio", d, 0);
        end
        rd(32'h1000, d);   chk("R1 pending", d, 0);
        rd(32'h2000, d);   chk("R1 enable", d, 0);
        rd(32'h200000, d); chk("R1 threshold", d, 0);
        rd(32'h200004, d); chk("R1 claim", d, 0);

        // R2 / R3 / R4: register read/write
        wr(32'h4, 32'd7);  rd(32'h4, d); chk("R2 prio 7", d, 7);
        wr(32'h4, 32'hF);  rd(32'h4, d); chk("R2 prio mask", d, 7);
        wr(32'h0, 32'h5);  rd(32'h0, d); chk("R2 source0 prio", d, 0);
        wr(32'h4, 32'd0);
        wr(32'h2000, 32'hFFFF_FFFF); rd(32'h2000, d); chk("R3 enable mask", d, 32'hE);
        wr(32'h2000, 32'h2); rd(32'h2000, d); chk("R3 enable bit1", d, 32'h2);
        for (int t = 0; t < 8; t++) begin
            wr(32'h200000, 32'(t)); rd(32'h200000, d); chk("R4 threshold", d, 32'(t));
        end

        // R5/R6/R7: sweep priority x threshold for source 1
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 8; t++) begin
                wr(32'h4, 32'(p));
                wr(32'h200000, 32'(t));
                @(negedge clk);
                uart_rx_valid = 1'b1;
                @(negedge clk);
                uart_rx_valid = 1'b0;
                rd(32'h1000, d);
                chk("R5 pending set", d, 32'h2);
                chk("R6 irq level", 32'(irq_out), 32'(p > t));
                rd(32'h200004, d);
                chk("R7 claim id", d, (p > t) ? 1 : 0);
                if (p > t) begin
                    rd(32'h1000, d); chk("R7 pending cleared", d, 0);
                    chk("R6 irq after claim", 32'(irq_out), 0);
                    wr(32'h200004, 32'd1);
                end
            end
        end
        // source 1 still pending (last combo p=7,t=7); claim it out
        wr(32'h200000, 32'd0);
        rd(32'h200004, d); chk("R7 claim leftover", d, 1);
        wr(32'h200004, 32'd1);

        // R6: one-clock registered timing
        wr(32'h4, 32'd1);
        @(negedge clk);
        uart_rx_valid = 1'b1;
        @(negedge clk);
        uart_rx_valid = 1'b0;
        chk("R6 irq not yet", 32'(irq_out), 0);
        @(negedge clk);
        chk("R6 irq one clock later", 32'(irq_out), 1);
        wr(32'h2000, 32'h0);
        chk("R6 irq drops with enable", 32'(irq_out), 0);
        wr(32'h2000, 32'h2);
        chk("R6 irq back with enable", 32'(irq_out), 1);
        rd(32'h200004, d); chk("R7 claim", d, 1);
        wr(32'h200004, 32'd1);

        // R8: all priority triples on three sources, bench model of pending
        wr(32'h2000, 32'hE);
        wr(32'h200000, 32'd0);
        pm = '0;
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                for (int c = 0; c < 8; c++) begin
                    pr[1] = a; pr[2] = b; pr[3] = c;
                    wr(32'h4, 32'(a));
                    wr(32'h8, 32'(b));
                    wr(32'hC, 32'(c));
                    pulse(3'b111);
                    pm = 3'b111;
                    rd(32'h1000, d); chk("R5 pending all", d, 32'hE);
                    for (int n = 0; n < 4; n++) begin
                        best = 0; exp_id = 0;
                        for (int s = 1; s <= 3; s++) begin
                            if (pm[s] && pr[s] > best) begin
                                best = pr[s]; exp_id = s;
                            end
                        end
                        chk("R6 irq vs model", 32'(irq_out), 32'(exp_id != 0));
                        rd(32'h200004, d);
                        chk("R8 claim order", d, 32'(exp_id));
                        if (exp_id == 0) break;
                        pm[exp_id] = 1'b0;
                        wr(32'h200004, 32'(exp_id));
                    end
                end
            end
        end
        wr(32'h4, 32'd0); wr(32'h8, 32'd0); wr(32'hC, 32'd0);
        // drain sources left pending with priority zero
        for (int s = 1; s <= 3; s++) begin
            wr(32'(4 * s), 32'd1);
            rd(32'h200004, d);
            if (d != 0) wr(32'h200004, d);
            wr(32'(4 * s), 32'd0);
        end
        rd(32'h1000, d); chk("R7 drained", d, 0);

        // R9: in-service source holds off re-pending and re-claim
        wr(32'h4, 32'd2);
        @(negedge clk);
        uart_rx_valid = 1'b1;
        repeat (2) @(negedge clk);
        rd(32'h200004, d); chk("R9 first claim", d, 1);
        repeat (3) @(negedge clk);
        rd(32'h1000, d); chk("R9 no repend", d, 0);
        rd(32'h200004, d); chk("R9 no reclaim", d, 0);
        chk("R9 irq low in service", 32'(irq_out), 0);
        wr(32'h200004, 32'd2);
        repeat (2) @(negedge clk);
        rd(32'h1000, d); chk("R9 wrong id keeps service", d, 0);
        wr(32'h200004, 32'd1);
        repeat (2) @(negedge clk);
        rd(32'h1000, d); chk("R9 repend after complete", d, 32'h2);
        chk("R9 irq after complete", 32'(irq_out), 1);
        uart_rx_valid = 1'b0;
        rd(32'h200004, d); chk("R9 claim again", d, 1);
        wr(32'h200004, 32'd1);

        // R10: read-only pending word, unmapped offsets
        pulse(3'b001);
        wr(32'h1000, 32'h0);
        rd(32'h1000, d); chk("R10 pending write ignored", d, 32'h2);
        wr(32'h1000, 32'hFFFF_FFFF);
        rd(32'h1000, d); chk("R10 pending write ignored", d, 32'h2);
        wr(32'h100, 32'hFFFF_FFFF);
        rd(32'h100, d);    chk("R10 unmapped", d, 0);
        rd(32'h3000, d);   chk("R10 unmapped", d, 0);
        rd(32'h200008, d); chk("R10 unmapped", d, 0);
        rd(32'h10, d);     chk("R10 beyond last source", d, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule